// File: doc/BRIEF.md
# Supply and Thermal Lockout Monitor

This block watches a digitized supply voltage and four digitized junction temperatures, one per half-bridge. It turns them into three lockout conditions: undervoltage, overvoltage and overtemperature. Each condition has a pair of thresholds that form a hysteresis window, so a sample that sits between the two thresholds keeps the condition as it was. When any of the three conditions is active, the block requests that every power output be switched off. Recovery happens on its own once the samples return to the safe side of the release threshold. Nothing is latched.

Only overvoltage and overtemperature count as reportable faults. A downstream fault encoder receives them on a combined report line and on their separate lock lines. Undervoltage switches the outputs off without raising a report. All thresholds are parameters in ADC code units.

The hysteresis state changes only on a cycle where the sample-valid strobe is high, and the outputs show the result one clock after that edge. Reset starts the block in undervoltage lockout. The lockout is then held until a valid sample shows the supply has reached the release level.

Top module: `supply_thermal_guard`

## Requirements
- R1: During and just after reset, uv_lock is 1, ov_lock is 0, ot_lock is 0, all_off is 1 and report_fault is 0.
- R2: A valid sample with vs_code strictly below UV_OFF sets uv_lock.
- R3: A valid sample with vs_code at or above UV_ON clears uv_lock. Codes from UV_OFF up to UV_ON-1 leave uv_lock unchanged.
- R4: A valid sample with vs_code strictly above OV_OFF sets ov_lock.
- R5: A valid sample with vs_code at or below OV_ON clears ov_lock. Codes from OV_ON+1 up to OV_OFF leave ov_lock unchanged.
- R6: temp_code packs sensor k in bits [8k+7:8k] (with the default width of 8). A valid sample in which any one sensor is at or above T_SD sets ot_lock.
- R7: ot_lock clears only on a valid sample in which every sensor is strictly below T_ON. If any sensor is at or above T_ON, ot_lock keeps its value.
- R8: all_off is 1 exactly when at least one of uv_lock, ov_lock and ot_lock is 1.
- R9: report_fault is 1 exactly when ov_lock or ot_lock is 1. uv_lock alone never raises it.
- R10: When smp_valid is 0, the vs_code and temp_code inputs are ignored and the three locks keep their values.
- R11: A change caused by a valid sample appears on the outputs at the first rising clock edge at which smp_valid is high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Strobe: the samples on this cycle are valid |
| vs_code | input | VS_W | Supply voltage sample in ADC codes |
| temp_code | input | N_SENS*TEMP_W | Packed temperature samples, sensor 0 in the low bits |
| uv_lock | output | 1 | Undervoltage lockout active |
| ov_lock | output | 1 | Overvoltage lockout active |
| ot_lock | output | 1 | Overtemperature lockout active |
| all_off | output | 1 | Request to switch all power outputs off |
| report_fault | output | 1 | Reportable fault (overvoltage or overtemperature) |

## Verification
Each lock is a single state bit that is updated once per strobe, so a wrong state shows on the ports one clock after the strobe that caused it. It stays visible until a later strobe moves the state across a threshold. The stimulus walks each window in both directions and lands on both boundary codes. A wrong comparison or a lost hysteresis bit therefore shows on the very next check as a lock that is set where it should be clear, or clear where it should be set. Other checks cover the cases that would otherwise stay hidden: one hot sensor at each lane position, one warm sensor blocking thermal release, and inputs that change while no strobe is present.

// File: rtl/lockout_pkg.sv
// Package: shared types and default widths for the supply/thermal lockout monitor.
// Assumes: every sample is an unsigned ADC code.
package lockout_pkg;

    // Says which side of the window trips a hysteresis comparator.
    typedef enum logic {
        TRIP_BELOW = 1'b0,  // condition sets when the sample falls under the set level
        TRIP_ABOVE = 1'b1   // condition sets when the sample rises over the set level
    } trip_dir_e;

    localparam int unsigned DEF_VS_W   = 10;
    localparam int unsigned DEF_TEMP_W = 8;
    localparam int unsigned DEF_N_SENS = 4;

endpackage

// File: rtl/hyst_window.sv
// Module: hyst_window
// A one-bit hysteresis comparator with two levels. The lock bit sets when the sample crosses
// SET_LVL in the direction DIR. It clears when the sample comes back to CLR_LVL or beyond.
// Samples between the two levels keep the state. The bit updates only when smp_valid is high.
// Assumes: for TRIP_BELOW, CLR_LVL > SET_LVL; for TRIP_ABOVE, CLR_LVL < SET_LVL.
module hyst_window
    import lockout_pkg::*;
#(
    parameter int unsigned W       = DEF_VS_W,
    parameter trip_dir_e   DIR     = TRIP_BELOW,
    parameter logic [W-1:0] SET_LVL = '0,
    parameter logic [W-1:0] CLR_LVL = '0,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] sample,
    output logic         lock
);

    logic trip;
    logic release_ok;
    logic lock_q;

    // Pick the comparator polarity from the parameter.
    generate
        if (DIR == TRIP_BELOW) begin : g_below
            assign trip       = (sample < SET_LVL);
            assign release_ok = (sample >= CLR_LVL);
        end else begin : g_above
            assign trip       = (sample > SET_LVL);
            assign release_ok = (sample <= CLR_LVL);
        end
    endgenerate

    // Purpose: hold the hysteresis state and update it once per valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= RST_VAL;
        end else if (smp_valid) begin
            if (lock_q && release_ok) begin
                lock_q <= 1'b0;
            end else if (!lock_q && trip) begin
                lock_q <= 1'b1;
            end
        end
    end

    assign lock = lock_q;

endmodule

// File: rtl/thermal_any.sv
// Module: thermal_any
// One shared thermal shutdown state for N_SENS sensors. It sets when any sensor is at or
// above T_SD. It clears only when every sensor is below T_ON. The state updates only when
// smp_valid is high.
// Assumes: T_ON < T_SD; sensor k sits in bits [k*TW +: TW] of temps.
module thermal_any
    import lockout_pkg::*;
#(
    parameter int unsigned  TW     = DEF_TEMP_W,
    parameter int unsigned  N_SENS = DEF_N_SENS,
    parameter logic [TW-1:0] T_SD  = '1,
    parameter logic [TW-1:0] T_ON  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [N_SENS*TW-1:0] temps,
    output logic                 ot_lock
);

    logic [N_SENS-1:0] hot;
    logic [N_SENS-1:0] cool;
    logic              any_hot;
    logic              all_cool;
    logic              ot_q;

    // One compare pair per sensor lane.
    generate
        for (genvar k = 0; k < N_SENS; k++) begin : g_lane
            assign hot[k]  = (temps[k*TW +: TW] >= T_SD);
            assign cool[k] = (temps[k*TW +: TW] <  T_ON);
        end
    endgenerate

    assign any_hot  = |hot;
    assign all_cool = &cool;

    // Purpose: shared overtemperature state with automatic release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ot_q <= 1'b0;
        end else if (smp_valid) begin
            if (ot_q && all_cool) begin
                ot_q <= 1'b0;
            end else if (!ot_q && any_hot) begin
                ot_q <= 1'b1;
            end
        end
    end

    assign ot_lock = ot_q;

endmodule

// File: rtl/supply_thermal_guard.sv
// Module: supply_thermal_guard (top)
// Combines the undervoltage window, the overvoltage window and the shared thermal shutdown
// into one all-outputs-off request and one reportable-fault line. Undervoltage is silent:
// it switches the outputs off but does not report.
// Assumes: one strobe qualifies the supply sample and all temperature samples together.
module supply_thermal_guard
    import lockout_pkg::*;
#(
    parameter int unsigned       VS_W   = DEF_VS_W,
    parameter int unsigned       TEMP_W = DEF_TEMP_W,
    parameter int unsigned       N_SENS = DEF_N_SENS,
    parameter logic [VS_W-1:0]   UV_OFF = 10'd112,
    parameter logic [VS_W-1:0]   UV_ON  = 10'd118,
    parameter logic [VS_W-1:0]   OV_ON  = 10'd563,
    parameter logic [VS_W-1:0]   OV_OFF = 10'd589,
    parameter logic [TEMP_W-1:0] T_ON   = 8'd150,
    parameter logic [TEMP_W-1:0] T_SD   = 8'd175
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [VS_W-1:0]          vs_code,
    input  logic [N_SENS*TEMP_W-1:0] temp_code,
    output logic                     uv_lock,
    output logic                     ov_lock,
    output logic                     ot_lock,
    output logic                     all_off,
    output logic                     report_fault
);

    // Undervoltage: trips below UV_OFF, releases at UV_ON; locked out from reset.
    hyst_window #(
        .W(VS_W), .DIR(TRIP_BELOW), .SET_LVL(UV_OFF), .CLR_LVL(UV_ON), .RST_VAL(1'b1)
    ) u_uv (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .sample(vs_code), .lock(uv_lock)
    );

    // Overvoltage: trips above OV_OFF, releases at OV_ON.
    hyst_window #(
        .W(VS_W), .DIR(TRIP_ABOVE), .SET_LVL(OV_OFF), .CLR_LVL(OV_ON), .RST_VAL(1'b0)
    ) u_ov (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .sample(vs_code), .lock(ov_lock)
    );

    // Thermal: any sensor hot sets, all sensors cool releases.
    thermal_any #(
        .TW(TEMP_W), .N_SENS(N_SENS), .T_SD(T_SD), .T_ON(T_ON)
    ) u_ot (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .temps(temp_code), .ot_lock(ot_lock)
    );

    // Purpose: merge the locks into the shutdown request and the reportable subset.
    always_comb begin
        all_off      = uv_lock | ov_lock | ot_lock;
        report_fault = ov_lock | ot_lock;
    end

endmodule

// File: rtl/supply_thermal_guard_chk.sv
// Module: supply_thermal_guard_chk
// Checker bound to supply_thermal_guard. Compares the lock outputs against the threshold
// rules, working only from the port values.
module supply_thermal_guard_chk #(
    parameter int unsigned       VS_W   = 10,
    parameter int unsigned       TEMP_W = 8,
    parameter int unsigned       N_SENS = 4,
    parameter logic [VS_W-1:0]   UV_OFF = 10'd112,
    parameter logic [VS_W-1:0]   UV_ON  = 10'd118,
    parameter logic [VS_W-1:0]   OV_ON  = 10'd563,
    parameter logic [VS_W-1:0]   OV_OFF = 10'd589,
    parameter logic [TEMP_W-1:0] T_ON   = 8'd150,
    parameter logic [TEMP_W-1:0] T_SD   = 8'd175
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_valid,
    input logic [VS_W-1:0]          vs_code,
    input logic [N_SENS*TEMP_W-1:0] temp_code,
    input logic                     uv_lock,
    input logic                     ov_lock,
    input logic                     ot_lock,
    input logic                     all_off,
    input logic                     report_fault
);

    logic c_any_hot;
    logic c_all_cool;

    // Purpose: independent view of the sensor lanes.
    always_comb begin
        c_any_hot  = 1'b0;
        c_all_cool = 1'b1;
        for (int k = 0; k < int'(N_SENS); k++) begin
            if (temp_code[k*TEMP_W +: TEMP_W] >= T_SD) c_any_hot = 1'b1;
            if (temp_code[k*TEMP_W +: TEMP_W] >= T_ON) c_all_cool = 1'b0;
        end
    end

    a_r2_uv_set: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && (vs_code < UV_OFF) |=> uv_lock);
    a_r3_uv_release: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && (vs_code >= UV_ON) |=> !uv_lock);
    a_r3_uv_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && (vs_code >= UV_OFF) && (vs_code < UV_ON) |=> $stable(uv_lock));
    a_r4_ov_set: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && (vs_code > OV_OFF) |=> ov_lock);
    a_r5_ov_release: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && (vs_code <= OV_ON) |=> !ov_lock);
    a_r5_ov_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && (vs_code > OV_ON) && (vs_code <= OV_OFF) |=> $stable(ov_lock));
    a_r6_ot_set: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && c_any_hot |=> ot_lock);
    a_r7_ot_release: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && c_all_cool |=> !ot_lock);
    a_r7_ot_warm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && ot_lock && !c_all_cool |=> ot_lock);
    a_r8_off_covers_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lock || ov_lock || ot_lock) |-> all_off);
    a_r9_uv_silent: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lock && !ov_lock && !ot_lock |-> !report_fault);
    a_r10_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable({uv_lock, ov_lock, ot_lock}));

endmodule

bind supply_thermal_guard supply_thermal_guard_chk #(
    .VS_W(VS_W), .TEMP_W(TEMP_W), .N_SENS(N_SENS),
    .UV_OFF(UV_OFF), .UV_ON(UV_ON), .OV_ON(OV_ON), .OV_OFF(OV_OFF),
    .T_ON(T_ON), .T_SD(T_SD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .vs_code(vs_code),
    .temp_code(temp_code), .uv_lock(uv_lock), .ov_lock(ov_lock), .ot_lock(ot_lock),
    .all_off(all_off), .report_fault(report_fault)
);

// File: tb/supply_thermal_guard_tb_top.sv
// Bench: walks a vector table of strobed samples, then runs directed reset and no-strobe tests.
module supply_thermal_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [9:0]  vs_code = '0;
    logic [31:0] temp_code = 32'h14141414;
    logic        uv_lock, ov_lock, ot_lock, all_off, report_fault;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    supply_thermal_guard dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .vs_code(vs_code),
        .temp_code(temp_code), .uv_lock(uv_lock), .ov_lock(ov_lock), .ot_lock(ot_lock),
        .all_off(all_off), .report_fault(report_fault)
    );

    // Vector: {vs[44:35], temps[34:3], uv[2], ov[1], ot[0]}
    localparam int NV = 24;
    localparam logic [44:0] VECS [0:NV-1] = '{
        {10'd100, 32'h14141414, 3'b100},  // R2 below UV_OFF, still locked
        {10'd115, 32'h14141414, 3'b100},  // R3 band holds lock
        {10'd118, 32'h14141414, 3'b000},  // R3 release at UV_ON
        {10'd112, 32'h14141414, 3'b000},  // R3 UV_OFF itself does not trip
        {10'd111, 32'h14141414, 3'b100},  // R2 trip one below UV_OFF
        {10'd117, 32'h14141414, 3'b100},  // R3 band holds
        {10'd400, 32'h14141414, 3'b000},
        {10'd589, 32'h14141414, 3'b000},  // R4 OV_OFF itself does not trip
        {10'd590, 32'h14141414, 3'b010},  // R4 trip
        {10'd564, 32'h14141414, 3'b010},  // R5 band holds
        {10'd563, 32'h14141414, 3'b000},  // R5 release at OV_ON
        {10'd400, 32'h14AF1414, 3'b001},  // R6 sensor 2 at T_SD
        {10'd400, 32'h96969696, 3'b001},  // R7 all at T_ON: hold
        {10'd400, 32'h14149696, 3'b001},  // R7 two warm: hold
        {10'd400, 32'h95951414, 3'b000},  // R7 all below T_ON: release
        {10'd400, 32'h141414AE, 3'b000},  // R6 one below T_SD
        {10'd400, 32'hAF141414, 3'b001},  // R6 sensor 3
        {10'd700, 32'hAF141414, 3'b011},  // R4 with R6
        {10'd50,  32'h14141414, 3'b100},  // R2 R5 R7 together
        {10'd400, 32'h14141414, 3'b000},
        {10'd400, 32'h141414AF, 3'b001},  // R6 sensor 0
        {10'd400, 32'h14141414, 3'b000},
        {10'd400, 32'h1414AF14, 3'b001},  // R6 sensor 1
        {10'd400, 32'h14141414, 3'b000}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic euv, input logic eov, input logic eot);
        check({tag, " uv_lock"}, uv_lock, euv);
        check({tag, " ov_lock"}, ov_lock, eov);
        check({tag, " ot_lock"}, ot_lock, eot);
        check({tag, " R8 all_off"}, all_off, euv | eov | eot);
        check({tag, " R9 report_fault"}, report_fault, eov | eot);
    endtask

    // Drive one strobed sample at a falling edge; the outputs are sampled at the next falling edge.
    task automatic strobe(input logic [9:0] v, input logic [31:0] t);
        @(negedge clk);
        vs_code = v;
        temp_code = t;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            strobe(VECS[i][44:35], VECS[i][34:3]);
            check_all($sformatf("vector %0d R2-R7", i), VECS[i][2], VECS[i][1], VECS[i][0]);
        end

        // R10: inputs that would trip every lock are ignored without a strobe.
        @(negedge clk);
        vs_code = 10'd50;
        temp_code = 32'hFFFFFFFF;
        repeat (4) @(negedge clk);
        check_all("R10 no strobe", 1'b0, 1'b0, 1'b0);
        vs_code = 10'd900;
        repeat (3) @(negedge clk);
        check_all("R10 no strobe high", 1'b0, 1'b0, 1'b0);

        // R11: no change before the edge that samples the strobe, change right after it.
        @(negedge clk);
        smp_valid = 1'b1;
        #1;
        check("R11 before edge ov_lock", ov_lock, 1'b0);
        check("R11 before edge ot_lock", ot_lock, 1'b0);
        @(negedge clk);
        smp_valid = 1'b0;
        check_all("R11 after edge", 1'b0, 1'b1, 1'b1);

        // R1: reset in the middle of a run restores the start-up state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 mid-run reset", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        strobe(10'd118, 32'h14141414);
        check_all("R3 release after reset", 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule